// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block sends data elements, written by a host, out of one serial data pin each time a frame sync arrives. A host-side holding register feeds a shift register. At a frame sync, the holding register moves into the shift register if the host has written it since the last move. One falling bit-clock edge after that move, a ready flag tells the host it may write the next element.

The block runs on one fast system clock. The serial bit clock and the frame sync are sampled inputs, and the block acts on their edges. Frame sync is taken on a falling bit-clock edge. Output bits change on rising bit-clock edges, most significant bit first. A programmable data delay of zero to two bit clocks comes before the first bit. The element length is programmable. If a frame sync finds no new data, the block raises an underflow flag and sends the previous element again.

Top module: `ser_tx`

## Requirements
- R1: After reset, `tx_ready` is 1, `tx_underflow` is 0 and `dout` is 0. The shift register is empty, so a frame sent with no host write sends all zeros.
- R2: While no frame is in progress, `dout` stays 0 whatever the bit clock does.
- R3: `fsync` is sampled only on a falling `bclk` edge. Output bits change only on rising `bclk` edges, most significant bit first. An element of L bits sends `wr_data[L-1:0]`, and the upper bits of the written word are ignored.
- R4: `cfg_delay` gives the number of zero bits sent before the first data bit: code 0, 1 or 2 gives 0, 1 or 2 bits, and code 3 acts as 2. `dout` is 0 during the delay bits and after the last bit of the element.
- R5: `cfg_len` code n gives an element length of 8+4n bits for n from 0 to 4. Codes 5, 6 and 7 give 32 bits.
- R6: At a frame sync, the holding register is copied into the shift register if it holds new data. `tx_ready` stays 0 on the falling edge that makes the copy and rises on the next falling `bclk` edge.
- R7: A host write (`wr_en` high for one clock) loads the holding register and clears `tx_ready` and `tx_underflow` on the next clock.
- R8: A frame sync with no host write since the last copy sets `tx_underflow` and sends the previous element again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock, sampled |
| fsync | input | 1 | Frame sync, sampled on a falling bit-clock edge |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 32 | Host write data |
| cfg_delay | input | 2 | Data delay code |
| cfg_len | input | 3 | Element length code |
| dout | output | 1 | Serial data output |
| tx_ready | output | 1 | Holding register may be written |
| tx_underflow | output | 1 | Frame sync found no new data |

## Verification
The bench sweeps every delay code against every length code, writing the word with bits set above the element. A design that ignored the length or the delay would send extra, missing or shifted bits, and one that leaked upper bits would send them first. Straight after each frame-sync edge the bench checks that `tx_ready` is still low, and one edge later that it is high, so a flag raised on the copy edge itself is caught. Frames with no write before them must send the old element again with underflow set. The first frame after reset must send zeros, which exposes a shift register that resets to stale or undefined contents.

// File: rtl/ser_tx.sv
`timescale 1ns/1ps
module ser_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   cfg_delay,
  input  logic [2:0]   cfg_len,
  output logic         dout,
  output logic         tx_ready,
  output logic         tx_underflow
);
  localparam int CW = $clog2(W + 1);

  logic         bclk_q, full, pend, busy;
  logic [W-1:0] hold, shreg;
  logic [1:0]   dly;
  logic [CW-1:0] left;

  wire fall = bclk_q & ~bclk;
  wire rise = ~bclk_q & bclk;

  function automatic logic [CW-1:0] len_of(input logic [2:0] c);
    return (c < 3'd5) ? CW'(8 + 4 * int'(c)) : CW'(32);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      full <= 1'b0;
      pend <= 1'b0;
      busy <= 1'b0;
      hold <= '0;
      shreg <= '0;
      dly <= '0;
      left <= '0;
      dout <= 1'b0;
      tx_ready <= 1'b1;
      tx_underflow <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (fall) begin
        if (pend) tx_ready <= 1'b1;
        pend <= 1'b0;
        if (fsync) begin
          if (full) begin
            shreg <= hold;
            full <= 1'b0;
            pend <= 1'b1;
          end else begin
            tx_underflow <= 1'b1;
          end
          busy <= 1'b1;
          dly <= (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
          left <= len_of(cfg_len);
        end
      end
      if (rise && busy) begin
        if (dly != 2'd0) begin
          dout <= 1'b0;
          dly <= dly - 2'd1;
        end else if (left != '0) begin
          dout <= shreg[left - CW'(1)];
          left <= left - CW'(1);
        end else begin
          dout <= 1'b0;
          busy <= 1'b0;
        end
      end
      if (wr_en) begin
        hold <= wr_data;
        full <= 1'b1;
        pend <= 1'b0;
        tx_ready <= 1'b0;
        tx_underflow <= 1'b0;
      end
    end
  end
endmodule

module ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic wr_en,
  input logic dout,
  input logic tx_ready,
  input logic tx_underflow,
  input logic busy
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dout);
  p_dout_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(bclk) && !$past(bclk, 2)));
  p_ready_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> ($past(bclk, 2) && !$past(bclk)));
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!tx_ready && !tx_underflow));
  p_underflow_at_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underflow) |-> ($past(fsync) && $past(bclk, 2) && !$past(bclk)));
endmodule

bind ser_tx ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .wr_en(wr_en),
  .dout(dout), .tx_ready(tx_ready), .tx_underflow(tx_underflow), .busy(busy)
);

// File: tb/ser_tx_bench.sv
`timescale 1ns/1ps
module ser_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] cfg_delay = '0;
  logic [2:0] cfg_len = '0;
  logic dout, tx_ready, tx_underflow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_tx u_ser_tx (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fs, output logic obs);
    bclk = 1'b1; fsync = fs;
    repeat (4) @(negedge clk);
    obs = dout;
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b0 && tx_underflow == 1'b0, "R7", int'({tx_ready, tx_underflow}), 0);
  endtask

  task automatic send(input logic [31:0] pat, input int dd, input int len, input bit uf, input string req);
    logic obs;
    cyc(1'b1, obs);
    chk(tx_underflow == uf, "R8", tx_underflow, uf);
    if (!uf) chk(tx_ready == 1'b0, "R6", tx_ready, 0);
    for (int k = 1; k <= dd + len + 1; k++) begin
      logic exp;
      cyc(1'b0, obs);
      if (k == 1 && !uf) chk(tx_ready == 1'b1, "R6", tx_ready, 1);
      if (k <= dd || k > dd + len) exp = 1'b0;
      else exp = pat[len - 1 - (k - 1 - dd)];
      chk(obs == exp, req, obs, exp);
    end
  endtask

  initial begin
    logic obs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1 && tx_underflow == 1'b0 && dout == 1'b0, "R1",
        int'({tx_ready, tx_underflow, dout}), 4);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, obs);
      chk(obs == 1'b0, "R2", obs, 0);
    end
    send(32'h0, 0, 8, 1'b1, "R1");
    for (int d = 0; d < 4; d++) begin
      for (int lc = 0; lc < 8; lc++) begin
        int dd, len;
        logic [31:0] pat;
        dd = (d == 3) ? 2 : d;
        len = (lc < 5) ? 8 + 4 * lc : 32;
        pat = 32'hC5A3_96E1 ^ (32'h1357_9BDF * (d * 8 + lc + 1));
        cfg_delay = 2'(d); cfg_len = 3'(lc);
        wr(pat);
        send(pat, dd, len, 1'b0, (lc == 0 || d == 3) ? "R4" : (lc < 5 ? "R3" : "R5"));
        if (lc == 7) send(pat, dd, len, 1'b1, "R8");
      end
    end
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, obs);
      chk(obs == 1'b0, "R2", obs, 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule